// File: doc/BRIEF.md
# Signed-Digit Serial Dot-Product Engine

This block computes the inner product of one convolution window. The weights of the window are presented in parallel as signed 8-bit values and held for the whole operation. The activations arrive serially, most significant digit first, one digit per tap per cycle. Each digit is a redundant signed digit taking the value -1, 0 or +1. Every cycle the engine doubles its running sum and adds the weighted digit sum of that cycle. Because the most significant digits come first, the running sum is a usable approximation of the final dot product after every digit, and it refines with each further digit.

The number of digits per operation is programmable from 2 to 7, so a layer can trade precision for latency. The final sum is scaled so that results at every precision share one binary point, the one a 7-digit operation has. A start pulse opens an operation. A done pulse marks the cycle the result is ready, and the next window may start in that very cycle.

Top module: `sd_dot_engine`

## Requirements
- R1: Each tap digit is carried on two wires (pos, neg): pos=1,neg=0 means +1; pos=0,neg=1 means -1; 00 and the illegal code 11 both count as 0.
- R2: A start while idle begins an operation. The most significant digits are taken in the start cycle and one further digit per cycle after it. Without a start, digits on the inputs have no effect.
- R3: The digit count P is sampled from prec_i in the start cycle only. Values 2 to 7 are used as given, and values 0 and 1 are treated as 2.
- R4: For each digit the running sum becomes twice its previous value plus the sum over taps of digit times weight.
- R5: done_o is high for exactly one cycle, the cycle after the P-th digit is taken, and busy_o is low in that cycle. done_o never rises earlier.
- R6: In the done cycle, result_o equals the final sum times 2^(7-P). It then holds that value until the next done.
- R7: In the cycle after the k-th digit is taken, partial_o equals the running sum times 2^(7-k).
- R8: A start while busy is ignored. The operation runs on unchanged and its result is unaffected.
- R9: A start in the done cycle is accepted, so windows can follow each other with no idle cycle.
- R10: After reset busy_o, done_o, result_o and partial_o are all zero.
- R11: The full-scale sum (every weight -128 or 127, every digit of one sign, P=7) is exact with no overflow, for example 146304 for weights of -128 and digits of -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| prec_i | input | 3 | Requested digit count |
| weights_i | input | 72 | Nine signed 8-bit weights, tap i in bits [8i+7:8i] |
| dig_pos_i | input | 9 | Per-tap plus wire of the current digit |
| dig_neg_i | input | 9 | Per-tap minus wire of the current digit |
| busy_o | output | 1 | Operation in progress after its start cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 19 | Scaled final dot product, two's complement |
| partial_o | output | 19 | Scaled running approximation |

## Verification
A wrong digit counter shows at the ports within one operation: done_o arrives early or late against the selected precision, and partial_o uses the wrong scaling in the very next cycle. A wrong digit decode or a wrong running sum shows in partial_o one cycle after the bad digit and then stays visible until the result. A result register that leaks or misses an update shows as a change of result_o outside a done cycle, or as a stale value in it. The bench runs every precision, illegal codes, starts while busy and chained windows, and it compares each partial and final value against sums it computes on its own.

// File: rtl/sd_dot_pkg.sv
`timescale 1ns/1ps
package sd_dot_pkg;

    localparam int unsigned SD_MIN_DIGITS = 2;
    localparam int unsigned SD_MAX_DIGITS = 7;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Bound a requested digit count to the supported range.
    function automatic int unsigned clamp_digits(input int unsigned req,
                                                 input int unsigned lo,
                                                 input int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/sd_tap_select.sv
`timescale 1ns/1ps
// One tap: turn a signed digit into +w, -w or zero.
module sd_tap_select #(
    parameter int WBITS = 8,
    parameter int SW    = 12
) (
    input  logic [WBITS-1:0]     weight_i,
    input  logic                 pos_i,
    input  logic                 neg_i,
    output logic signed [SW-1:0] term_o
);
    logic signed [SW-1:0] w_ext;

    assign w_ext = {{(SW-WBITS){weight_i[WBITS-1]}}, weight_i};

    always_comb begin
        // 00 and the illegal 11 both select nothing
        if (pos_i && !neg_i)      term_o = w_ext;
        else if (neg_i && !pos_i) term_o = -w_ext;
        else                      term_o = '0;
    end
endmodule

// File: rtl/sd_tap_sum.sv
`timescale 1ns/1ps
// Add the selected terms of all taps.
module sd_tap_sum #(
    parameter int TAPS = 9,
    parameter int SW   = 12
) (
    input  logic [TAPS*SW-1:0]   terms_i,
    output logic signed [SW-1:0] sum_o
);
    always_comb begin
        sum_o = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum_o = sum_o + $signed(terms_i[t*SW +: SW]);
        end
    end
endmodule

// File: rtl/sd_dot_acc.sv
`timescale 1ns/1ps
// Digit counter, shift-and-add accumulator and result register.
module sd_dot_acc import sd_dot_pkg::*; #(
    parameter int SW   = 12,
    parameter int RW   = 19,
    parameter int MAXD = 7,
    parameter int CW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CW-1:0]        prec_i,
    input  logic signed [SW-1:0] step_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic signed [RW-1:0] result_o,
    output logic signed [RW-1:0] partial_o
);
    typedef struct packed {
        phase_e               phase;
        logic [CW-1:0]        cnt;
        logic [CW-1:0]        prec;
        logic signed [RW-1:0] acc;
        logic signed [RW-1:0] res;
        logic                 done;
    } acc_state_t;

    acc_state_t           st_d, st_q;
    logic signed [RW-1:0] step_ext;
    logic signed [RW-1:0] acc_next;
    logic [CW-1:0]        prec_req;
    logic [CW-1:0]        cnt_inc;
    logic [CW-1:0]        fin_sh;
    logic [CW-1:0]        part_sh;

    assign step_ext = {{(RW-SW){step_i[SW-1]}}, step_i};
    assign acc_next = (st_q.acc <<< 1) + step_ext;
    assign prec_req = CW'(clamp_digits(32'(prec_i), SD_MIN_DIGITS, MAXD));
    assign cnt_inc  = st_q.cnt + CW'(1);
    assign fin_sh   = CW'(MAXD) - st_q.prec;
    assign part_sh  = CW'(MAXD) - st_q.cnt;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase = PH_RUN;
                st_d.prec  = prec_req;
                st_d.cnt   = CW'(1);
                st_d.acc   = step_ext;
            end
        end else begin
            // start_i is not looked at while running
            st_d.acc = acc_next;
            st_d.cnt = cnt_inc;
            if (cnt_inc == st_q.prec) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.res   = acc_next <<< fin_sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = (st_q.phase == PH_RUN);
    assign done_o    = st_q.done;
    assign result_o  = st_q.res;
    assign partial_o = st_q.acc <<< part_sh;
endmodule

// File: rtl/sd_dot_engine.sv
`timescale 1ns/1ps
module sd_dot_engine import sd_dot_pkg::*; #(
    parameter  int TAPS  = 9,
    parameter  int WBITS = 8,
    parameter  int MAXD  = SD_MAX_DIGITS,
    localparam int DW    = $clog2(MAXD + 1),
    localparam int SW    = WBITS + $clog2(TAPS),
    localparam int RW    = SW + MAXD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [DW-1:0]         prec_i,
    input  logic [TAPS*WBITS-1:0] weights_i,
    input  logic [TAPS-1:0]       dig_pos_i,
    input  logic [TAPS-1:0]       dig_neg_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic signed [RW-1:0]  result_o,
    output logic signed [RW-1:0]  partial_o
);
    logic [TAPS*SW-1:0]   tap_terms;
    logic signed [SW-1:0] step_sum;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic signed [SW-1:0] term;
        sd_tap_select #(.WBITS(WBITS), .SW(SW)) u_sel (
            .weight_i (weights_i[t*WBITS +: WBITS]),
            .pos_i    (dig_pos_i[t]),
            .neg_i    (dig_neg_i[t]),
            .term_o   (term)
        );
        assign tap_terms[t*SW +: SW] = term;
    end

    sd_tap_sum #(.TAPS(TAPS), .SW(SW)) u_sum (
        .terms_i (tap_terms),
        .sum_o   (step_sum)
    );

    sd_dot_acc #(.SW(SW), .RW(RW), .MAXD(MAXD), .CW(DW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .prec_i    (prec_i),
        .step_i    (step_sum),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .partial_o (partial_o)
    );
endmodule

// File: rtl/sd_dot_checker.sv
`timescale 1ns/1ps
module sd_dot_checker #(
    parameter int RW   = 19,
    parameter int MAXD = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic signed [RW-1:0] result_o
);
    logic [3:0] run_ctr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_ctr <= '0;
        else if (!busy_o)       run_ctr <= '0;
        else if (run_ctr != '1) run_ctr <= run_ctr + 4'd1;
    end

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && start_i) |=> busy_o); // R2
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> (32'(run_ctr) < MAXD - 1)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R5
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!busy_o && $past(busy_o))); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o)); // R6
endmodule

bind sd_dot_engine sd_dot_checker #(.RW(RW), .MAXD(MAXD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sim_sd_dot_engine.sv
`timescale 1ns/1ps
module sim_sd_dot_engine;
    localparam int TAPS = 9;
    localparam int WB   = 8;
    localparam int MAXD = 7;
    localparam int RW   = 19;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [2:0]           prec_i = '0;
    logic [TAPS*WB-1:0]   weights_i = '0;
    logic [TAPS-1:0]      dig_pos_i = '0;
    logic [TAPS-1:0]      dig_neg_i = '0;
    logic                 busy_o, done_o;
    logic signed [RW-1:0] result_o, partial_o;

    int          checks = 0;
    int          errors = 0;
    int          wv [TAPS];
    logic [TAPS-1:0] pv [MAXD];
    logic [TAPS-1:0] nv [MAXD];
    int unsigned rng = 32'h1234_5678;
    longint      last_result = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    sd_dot_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i),
        .weights_i(weights_i), .dig_pos_i(dig_pos_i), .dig_neg_i(dig_neg_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .partial_o(partial_o)
    );

    function automatic int unsigned next_rand();
        rng = rng * 32'd1103515245 + 32'd12345;
        return rng >> 16;
    endfunction

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int digit_val(input logic p, input logic n);
        if (p && !n) return 1;
        if (n && !p) return -1;
        return 0;
    endfunction

    function automatic longint step_of(input int k);
        longint s = 0;
        for (int i = 0; i < TAPS; i++) s += digit_val(pv[k][i], nv[k][i]) * wv[i];
        return s;
    endfunction

    // mode 0 random, 1 all -128, 2 all +127
    task automatic load_weights(input int mode);
        for (int i = 0; i < TAPS; i++) begin
            if (mode == 1)      wv[i] = -128;
            else if (mode == 2) wv[i] = 127;
            else                wv[i] = int'(next_rand() % 256) - 128;
            weights_i[i*WB +: WB] = 8'(wv[i]);
        end
    endtask

    // mode 0 legal random, 1 any code, 2 all +1, 3 all -1, 4 all illegal 11
    task automatic make_digits(input int mode);
        for (int k = 0; k < MAXD; k++) begin
            for (int i = 0; i < TAPS; i++) begin
                int unsigned r = next_rand();
                case (mode)
                    0: begin pv[k][i] = (r % 3) == 1; nv[k][i] = (r % 3) == 2; end
                    1: begin pv[k][i] = r[0]; nv[k][i] = r[1]; end
                    2: begin pv[k][i] = 1'b1; nv[k][i] = 1'b0; end
                    3: begin pv[k][i] = 1'b0; nv[k][i] = 1'b1; end
                    default: begin pv[k][i] = 1'b1; nv[k][i] = 1'b1; end
                endcase
            end
        end
    endtask

    // Starts at a negedge, ends at the negedge of the done cycle.
    task automatic feed_window(input int prec_set, input int prec_eff, input int inject_at, input string tag);
        longint acc = 0;
        for (int k = 0; k < prec_eff; k++) begin
            start_i   = (k == 0) || (k == inject_at);
            prec_i    = (k == 0) ? 3'(prec_set) : 3'(next_rand());
            dig_pos_i = pv[k];
            dig_neg_i = nv[k];
            @(posedge clk);
            @(negedge clk);
            acc = acc * 2 + step_of(k);
            if (k < prec_eff - 1) begin
                check_eq("R5", {tag, " done early"}, longint'(done_o), 0);
                check_eq("R2", {tag, " busy mid-run"}, longint'(busy_o), 1);
                check_eq("R7", {tag, " partial"}, longint'(partial_o), acc * (64'sd1 <<< (MAXD - k - 1)));
            end
        end
        start_i   = 1'b0;
        dig_pos_i = '0;
        dig_neg_i = '0;
        check_eq("R5", {tag, " done at end"}, longint'(done_o), 1);
        check_eq("R5", {tag, " busy at done"}, longint'(busy_o), 0);
        check_eq("R6", {tag, " R4 result"}, longint'(result_o), acc * (64'sd1 <<< (MAXD - prec_eff)));
        check_eq("R7", {tag, " final partial"}, longint'(partial_o), acc * (64'sd1 <<< (MAXD - prec_eff)));
        if (inject_at >= 0)
            check_eq("R8", {tag, " start while busy ignored"}, longint'(result_o), acc * (64'sd1 <<< (MAXD - prec_eff)));
        last_result = acc * (64'sd1 <<< (MAXD - prec_eff));
    endtask

    // Idle cycles with random digits and no start: nothing moves.
    task automatic idle_after(input string tag);
        for (int c = 0; c < 2; c++) begin
            dig_pos_i = TAPS'(next_rand());
            dig_neg_i = TAPS'(next_rand());
            @(posedge clk);
            @(negedge clk);
            check_eq("R5", {tag, " done after pulse"}, longint'(done_o), 0);
            check_eq("R2", {tag, " idle busy"}, longint'(busy_o), 0);
            check_eq("R6", {tag, " result held"}, longint'(result_o), last_result);
        end
        dig_pos_i = '0;
        dig_neg_i = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R10", "busy", longint'(busy_o), 0);
        check_eq("R10", "done", longint'(done_o), 0);
        check_eq("R10", "result", longint'(result_o), 0);
        check_eq("R10", "partial", longint'(partial_o), 0);
    endtask

    task automatic t_every_precision();
        for (int p = 2; p <= MAXD; p++) begin
            load_weights(0);
            make_digits(0);
            feed_window(p, p, -1, "R3 precision");
            idle_after("R3 precision");
        end
    endtask

    task automatic t_illegal_codes();
        load_weights(0);
        make_digits(1);
        feed_window(5, 5, -1, "R1 mixed codes");
        idle_after("R1 mixed codes");
        make_digits(4);
        feed_window(6, 6, -1, "R1 all 11");
        check_eq("R1", "all 11 gives zero", longint'(result_o), 0);
        idle_after("R1 all 11");
    endtask

    task automatic t_clamp();
        load_weights(0);
        make_digits(0);
        feed_window(0, 2, -1, "R3 clamp 0");
        idle_after("R3 clamp 0");
        make_digits(0);
        feed_window(1, 2, -1, "R3 clamp 1");
        idle_after("R3 clamp 1");
    endtask

    task automatic t_busy_start();
        load_weights(0);
        make_digits(0);
        feed_window(7, 7, 3, "R8 inject");
        idle_after("R8 inject");
        make_digits(0);
        feed_window(4, 4, 1, "R8 inject early");
        idle_after("R8 inject early");
    endtask

    task automatic t_back_to_back();
        load_weights(0);
        make_digits(0);
        feed_window(3, 3, -1, "R9 first");
        make_digits(0);
        feed_window(6, 6, -1, "R9 second");
        make_digits(0);
        feed_window(2, 2, -1, "R9 third");
        idle_after("R9 chain");
    endtask

    task automatic t_full_scale();
        load_weights(1);
        make_digits(3);
        feed_window(7, 7, -1, "R11 neg digits");
        check_eq("R11", "-128 x -1 full scale", longint'(result_o), 146304);
        idle_after("R11 a");
        make_digits(2);
        feed_window(7, 7, -1, "R11 pos digits");
        check_eq("R11", "-128 x +1 full scale", longint'(result_o), -146304);
        idle_after("R11 b");
        load_weights(2);
        feed_window(7, 7, -1, "R11 max weight");
        check_eq("R11", "127 x +1 full scale", longint'(result_o), 145161);
        idle_after("R11 c");
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_sim();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_every_precision();
        t_illegal_codes();
        t_clamp();
        t_busy_start();
        t_back_to_back();
        t_full_scale();
        finish_sim();
    end
endmodule